// File: doc/BRIEF.md
# 16-bit SEC-DED Memory Error Corrector

This block guards a 16-bit memory word with a 6-bit checkword. It detects and repairs any single flipped bit and detects, without repairing, any pair of flipped bits. A 2-bit cycle selector steps the block through its four cycle types.

- In the generate cycle it computes the checkword for the word being written and drives it out.
- In the fetch cycle it receives data and checkword from memory.
- In the latch cycle it registers both and evaluates the error flags.
- In the repair cycle it drives the corrected word onto the data output and the 6-bit syndrome onto the checkword output. The syndrome names the failing memory bit.

The bidirectional data and checkword buses are split into separate input and output buses, each with an output enable. The pads join them outside the block. The selector and flags are plain level signals, with no handshake. A memory controller steps the selector once per cycle, and no back-pressure exists.

Top module: `edac16`

## Requirements
- R1: The selector `mode` encodes 00 as generate, 01 as fetch, 11 as latch and 10 as repair. `chk_oe` is high only in generate and repair. `data_oe` is high only in repair.
- R2: Each data bit i has a 6-bit code. It is the i-th value, counting upward from zero, among all 6-bit values with exactly three ones, leaving out 0x07, 0x0B, 0x34 and 0x38. Check bit j is the XOR of the data bits whose code has bit j set, and bits 0 and 1 of the checkword are then inverted. In generate, `chk_out` carries this checkword for `data_in`.
- R3: In generate and fetch, both `single_err` and `double_err` are low.
- R4: On a rising clock edge while `mode` is 11, `data_in` and `chk_in` are registered. A clean stored pair then gives low flags, a zero syndrome and unchanged data in repair.
- R5: A single flipped data bit i gives a syndrome equal to the code of bit i. `single_err` is high, `double_err` is low, and bit i is inverted on `data_out`.
- R6: A single flipped check bit j gives a one-hot syndrome with bit j set. `single_err` is high, `double_err` is low, and data is unchanged.
- R7: Any two flipped bits give a nonzero even-weight syndrome. Both flags are high and the received data passes unchanged.
- R8: A weight-3 syndrome that equals no data-bit code (0x07, 0x0B, 0x34, 0x38) raises both flags and passes the data unchanged.
- R9: A stored word of all zeros (checkword 0x00) and one of all ones (0xFFFF, checkword 0x3F) are each reported with both flags high.
- R10: In repair, `data_out`, `chk_out` and the flags depend only on the registered pair. Changes on `data_in` and `chk_in` have no effect.
- R11: Reset clears the registered pair to zero. Repair straight after reset therefore shows data 0x0000, syndrome 0x03 and both flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Cycle selector (00 generate, 01 fetch, 11 latch, 10 repair) |
| data_in | input | 16 | Data arriving from the bus |
| data_out | output | 16 | Corrected data in repair, zero otherwise |
| data_oe | output | 1 | Enable for the data output pads |
| chk_in | input | 6 | Checkword arriving from memory |
| chk_out | output | 6 | Checkword in generate, syndrome in repair, zero otherwise |
| chk_oe | output | 1 | Enable for the checkword output pads |
| single_err | output | 1 | Any error present (latch and repair) |
| double_err | output | 1 | Uncorrectable error present (latch and repair) |

## Verification
The bench builds the block at its only widths, 16 data bits and 6 check bits. These widths fix the 16-entry code table, so every single-bit position in both fields can be reached exhaustively. Pairs of data bits, mixed data and check pairs, check pairs, a triple check-bit flip that lands on an unused weight-3 code, and the all-zero and all-one stored words are also driven. In every repair cycle the bus is flipped to its complement, which exercises isolation from live bus inputs.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  localparam logic [CHK_W-1:0] INV_MASK = 6'b000011;

  typedef enum logic [1:0] {
    MODE_GEN   = 2'b00,
    MODE_FETCH = 2'b01,
    MODE_LATCH = 2'b11,
    MODE_FIX   = 2'b10
  } edac_mode_e;

  function automatic logic code_skipped(input logic [CHK_W-1:0] v);
    return (v == 6'h07) || (v == 6'h0B) || (v == 6'h34) || (v == 6'h38);
  endfunction

  // Code assigned to data bit idx: idx-th weight-3 value in ascending order.
  function automatic logic [CHK_W-1:0] bit_code(input int idx);
    logic [CHK_W-1:0] r;
    logic [CHK_W-1:0] v;
    int n;
    r = '0;
    n = 0;
    for (int c = 0; c < (1 << CHK_W); c++) begin
      v = CHK_W'(c);
      if ($countones(v) == 3 && !code_skipped(v)) begin
        if (n == idx) r = v;
        n++;
      end
    end
    return r;
  endfunction

  // Data bits that feed check bit j.
  function automatic logic [DATA_W-1:0] col_mask(input int j);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0] cd;
    for (int i = 0; i < DATA_W; i++) begin
      cd = bit_code(i);
      m[i] = cd[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/edac_checkgen.sv
module edac_checkgen
  import edac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk_raw
);
  for (genvar j = 0; j < CW; j++) begin : g_col
    localparam logic [DW-1:0] COL = col_mask(j);
    assign chk_raw[j] = ^(data & COL);
  end
endmodule

// File: rtl/edac_syn_decode.sv
module edac_syn_decode
  import edac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [CW-1:0] syn,
  output logic [DW-1:0] flip,
  output logic          any_err,
  output logic          uncorr
);
  logic [DW-1:0] hit;
  logic          chk_only;

  for (genvar i = 0; i < DW; i++) begin : g_hit
    localparam logic [CW-1:0] CODE = bit_code(i);
    assign hit[i] = (syn == CODE);
  end

  assign chk_only = ($countones(syn) == 1);
  assign flip     = hit;
  assign any_err  = |syn;
  assign uncorr   = (|syn) && !chk_only && !(|hit);
endmodule

// File: rtl/edac_capture.sv
module edac_capture #(
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d_in,
  input  logic [CW-1:0] c_in,
  output logic [DW-1:0] d_q,
  output logic [CW-1:0] c_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      c_q <= '0;
    end else if (load) begin
      d_q <= d_in;
      c_q <= c_in;
    end
  end
endmodule

// File: rtl/edac16.sv
module edac16
  import edac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [CHK_W-1:0]  chk_in,
  output logic [CHK_W-1:0]  chk_out,
  output logic              chk_oe,
  output logic              single_err,
  output logic              double_err
);
  edac_mode_e        cyc;
  logic [DATA_W-1:0] data_q;
  logic [CHK_W-1:0]  chk_q;
  logic [CHK_W-1:0]  raw_w;
  logic [CHK_W-1:0]  raw_q;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic              any_err;
  logic              uncorr;

  assign cyc = edac_mode_e'(mode);

  edac_capture #(.DW(DATA_W), .CW(CHK_W)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cyc == MODE_LATCH),
    .d_in (data_in),
    .c_in (chk_in),
    .d_q  (data_q),
    .c_q  (chk_q)
  );

  edac_checkgen #(.DW(DATA_W), .CW(CHK_W)) u_gen_wr (
    .data   (data_in),
    .chk_raw(raw_w)
  );

  edac_checkgen #(.DW(DATA_W), .CW(CHK_W)) u_gen_rd (
    .data   (data_q),
    .chk_raw(raw_q)
  );

  // Undo the stored inversion, then compare with the regenerated parity.
  assign syn = (chk_q ^ INV_MASK) ^ raw_q;

  edac_syn_decode #(.DW(DATA_W), .CW(CHK_W)) u_dec (
    .syn    (syn),
    .flip   (flip),
    .any_err(any_err),
    .uncorr (uncorr)
  );

  always_comb begin
    data_out   = '0;
    data_oe    = 1'b0;
    chk_out    = '0;
    chk_oe     = 1'b0;
    single_err = 1'b0;
    double_err = 1'b0;
    unique case (cyc)
      MODE_GEN: begin
        chk_out = raw_w ^ INV_MASK;
        chk_oe  = 1'b1;
      end
      MODE_FETCH: ;
      MODE_LATCH: begin
        single_err = any_err;
        double_err = uncorr;
      end
      MODE_FIX: begin
        data_out   = uncorr ? data_q : (data_q ^ flip);
        data_oe    = 1'b1;
        chk_out    = syn;
        chk_oe     = 1'b1;
        single_err = any_err;
        double_err = uncorr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/edac16_chk.sv
module edac16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic [15:0] data_out,
  input logic        data_oe,
  input logic [5:0]  chk_out,
  input logic        chk_oe,
  input logic        single_err,
  input logic        double_err
);
  // R1: generate drives only the checkword pads
  p_gen_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (chk_oe && !data_oe));

  // R1: repair drives both sets of pads
  p_fix_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (chk_oe && data_oe));

  // R3: flags quiet in generate and fetch
  p_flags_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0) |-> (!single_err && !double_err));

  // R7: uncorrectable implies an error was seen
  p_dual_has_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    double_err |-> single_err);

  // R4: clean syndrome when no error is flagged in repair
  p_clean_syn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !single_err) |-> (chk_out == 6'h00));

  // R5: a correctable error has syndrome weight one or three
  p_single_weight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && single_err && !double_err) |->
      ($countones(chk_out) == 1 || $countones(chk_out) == 3));

  // R7: a nonzero even-weight syndrome is always uncorrectable
  p_even_is_dual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && chk_out != 6'h00 && !chk_out[0] ^ ^chk_out[5:1] ) |-> double_err);

  // R10: outputs hold while repair continues, whatever the bus does
  p_fix_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b10) |->
      ($stable(data_out) && $stable(chk_out) && $stable(double_err)));
endmodule

bind edac16 edac16_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .data_out  (data_out),
  .data_oe   (data_oe),
  .chk_out   (chk_out),
  .chk_oe    (chk_oe),
  .single_err(single_err),
  .double_err(double_err)
);

// File: tb/edac16_bench.sv
module edac16_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        data_oe;
  logic [5:0]  chk_in = '0;
  logic [5:0]  chk_out;
  logic        chk_oe;
  logic        single_err;
  logic        double_err;
  logic        strobe = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] d;
    logic [5:0]  s;
    logic        se;
    logic        de;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [5:0] codes [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  edac16 u_edac16 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .chk_in(chk_in), .chk_out(chk_out), .chk_oe(chk_oe),
    .single_err(single_err), .double_err(double_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of the write checkword, built bit by bit from the code table.
  function automatic logic [5:0] model_chk(input logic [15:0] d);
    logic [5:0] acc = 6'b000011;
    for (int i = 0; i < 16; i++) if (d[i]) acc ^= codes[i];
    return acc;
  endfunction

  function automatic exp_t model_fix(input logic [15:0] d, input logic [5:0] c, input string tag);
    exp_t e;
    e.s   = c ^ model_chk(d);
    e.d   = d;
    e.tag = tag;
    e.se  = (e.s != 0);
    e.de  = e.se;
    if ($countones(e.s) == 1) e.de = 1'b0;
    for (int i = 0; i < 16; i++)
      if (e.s == codes[i]) begin
        e.de = 1'b0;
        e.d[i] = ~d[i];
      end
    return e;
  endfunction

  // Full cycle: generate, corrupt, fetch, latch, repair.
  task automatic run_word(input logic [15:0] d, input logic [15:0] dflip, input logic [5:0] cflip, input string tag);
    logic [5:0] cw;
    @(posedge clk); #1;
    mode = 2'b00; data_in = d;
    #2;
    check(chk_out == model_chk(d), "R2 checkword", 32'(chk_out), 32'(model_chk(d)));
    check(chk_oe && !data_oe, "R1 generate enables", {30'd0, chk_oe, data_oe}, 32'h2);
    check(!single_err && !double_err, "R3 flags in generate", {30'd0, single_err, double_err}, 0);
    cw = model_chk(d);
    raw_store(d ^ dflip, cw ^ cflip, tag);
  endtask

  task automatic raw_store(input logic [15:0] d, input logic [5:0] c, input string tag);
    @(posedge clk); #1;
    mode = 2'b01; data_in = d; chk_in = c;
    #2;
    check(!data_oe && !chk_oe, "R1 fetch enables", {30'd0, chk_oe, data_oe}, 0);
    check(!single_err && !double_err, "R3 flags in fetch", {30'd0, single_err, double_err}, 0);
    @(posedge clk); #1;
    mode = 2'b11;
    @(posedge clk); #1;
    sb.push_back(model_fix(d, c, tag));
    mode = 2'b10; strobe = 1'b1;
    data_in = ~d; chk_in = ~c;   // R10: live bus changes must not matter
    @(posedge clk); #1;
    strobe = 1'b0;
    @(posedge clk); #1;
    mode = 2'b01;
  endtask

  // Monitor: compares repair outputs against queued expectations.
  always @(negedge clk) begin
    if (strobe) begin
      if (sb.size() == 0) begin
        check(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(data_out == e.d, {e.tag, " data"}, 32'(data_out), 32'(e.d));
        check(chk_out == e.s, {e.tag, " syndrome"}, 32'(chk_out), 32'(e.s));
        check({single_err, double_err} == {e.se, e.de}, {e.tag, " flags"},
              {30'd0, single_err, double_err}, {30'd0, e.se, e.de});
        check(data_oe && chk_oe, "R1 repair enables", {30'd0, data_oe, chk_oe}, 32'h3);
      end
    end
  end

  initial begin
    int n;
    n = 0;
    for (int v = 0; v < 64; v++) begin
      logic [5:0] c6;
      c6 = 6'(v);
      if ($countones(c6) == 3 && c6 != 6'h07 && c6 != 6'h0B && c6 != 6'h34 && c6 != 6'h38) begin
        if (n < 16) codes[n] = c6;
        n++;
      end
    end

    repeat (3) @(posedge clk);
    #1 mode = 2'b10;
    #2;
    // R11: reset state of the registered pair
    check(data_out == 16'h0000 && chk_out == 6'h03, "R11 reset data/syndrome",
          {10'd0, chk_out, data_out}, 32'h0003_0000);
    check(single_err && double_err, "R11 reset flags", {30'd0, single_err, double_err}, 32'h3);
    @(posedge clk); #1;
    rst_n = 1'b1; mode = 2'b01;

    // R4: clean words
    run_word(16'h1234, 0, 0, "R4 clean a");
    run_word(16'hA5C3, 0, 0, "R4 clean b");
    run_word(16'h8001, 0, 0, "R4 clean c");
    // R5: every data bit
    for (int i = 0; i < 16; i++) run_word(16'h5A3C, 16'(1) << i, 0, "R5 data single");
    // R6: every check bit
    for (int j = 0; j < 6; j++) run_word(16'hC0DE, 0, 6'(1) << j, "R6 check single");
    // R7: double errors
    for (int i = 0; i < 11; i++) run_word(16'h0F0F, (16'(1) << i) | (16'(1) << (i + 5)), 0, "R7 data pair");
    for (int j = 0; j < 6; j++) run_word(16'hFFF0, 16'(1) << (j * 2), 6'(1) << j, "R7 mixed pair");
    run_word(16'h7777, 0, 6'h21, "R7 check pair");
    // R8: triple check flip landing on an unused weight-3 code
    run_word(16'h3C3C, 0, 6'h07, "R8 unused code 07");
    run_word(16'h0001, 0, 6'h38, "R8 unused code 38");
    // R9: all-zero and all-one stored words
    raw_store(16'h0000, 6'h00, "R9 all zero");
    raw_store(16'hFFFF, 6'h3F, "R9 all one");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule